// File: doc/BRIEF.md
# DMA Channel Control Register

This block is the control and configuration register of a single DMA channel, reached through a simple synchronous register bus. It stores the channel enable, three interrupt enables (complete, half, error), the transfer direction and the circular-mode bit. Three event pulses from the transfer engine (error, half, complete) set sticky status flags. Each flag is cleared by writing 1 to its own bit in a separate clear register. The block also steers the peripheral-side and memory-side transfer attributes onto the source and destination outputs.

While the channel is enabled, the configuration is frozen. Software can still drop the enable. An error pulse clears the enable at once. The enable cannot be set again while the error flag is up. At the end of a pass the channel either signals a reload (circular mode) or goes idle with the enable left set.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the control word, the status word, every interrupt output and the reload output are 0.
- R2: The control word at offset 0x0 has this layout: bit 0 enable, bit 1 complete-interrupt enable, bit 2 half-interrupt enable, bit 3 error-interrupt enable, bit 4 direction, bit 5 circular. With the channel disabled, a write stores bits 5..1 as given, and bits REG_W-1..6 always read 0.
- R3: While the enable reads 1, writes leave bits 5..1 unchanged, and a write with bit 0 = 0 clears the enable.
- R4: An error pulse sets the error flag (status bit 2 at offset 0x8) and clears the enable at the same clock edge.
- R5: While the error flag is set, a write of 1 to the enable is ignored. Writing 1 to bit 2 of the clear register (offset 0x4) clears the flag, and after that the enable can be set.
- R6: With direction 0, the source takes size, increment and address from the peripheral inputs, and the destination takes them from the memory inputs.
- R7: With direction 1, the source takes them from the memory inputs, and the destination takes them from the peripheral inputs.
- R8: Status bit 0 (complete) and bit 1 (half) are sticky and are cleared by writing 1 to clear-register bits 0 and 1. Each interrupt output is its flag ANDed with its enable bit.
- R9: In circular mode, a complete pulse on an enabled, active channel raises reload_pulse in the same cycle, and the channel stays active. Outside circular mode, reload_pulse stays 0.
- R10: Outside circular mode, a complete pulse leaves the enable at 1 and clears the active marker (status bit 3). Setting the enable from 0 sets the active marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | BUS_AW | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr (combinational) |
| ev_err | input | 1 | Transfer error pulse |
| ev_half | input | 1 | Half transfer pulse |
| ev_done | input | 1 | Transfer complete pulse |
| per_size | input | SIZE_W | Peripheral-side element size |
| per_inc | input | 1 | Peripheral-side increment |
| per_addr | input | XADDR_W | Peripheral address |
| mem_size | input | SIZE_W | Memory-side element size |
| mem_inc | input | 1 | Memory-side increment |
| mem_addr | input | XADDR_W | Memory address |
| src_size | output | SIZE_W | Source element size |
| src_inc | output | 1 | Source increment |
| src_addr | output | XADDR_W | Source address |
| dst_size | output | SIZE_W | Destination element size |
| dst_inc | output | 1 | Destination increment |
| dst_addr | output | XADDR_W | Destination address |
| ch_en | output | 1 | Enable bit |
| ch_circ | output | 1 | Circular-mode bit |
| ch_active | output | 1 | Channel enabled and not idle |
| reload_pulse | output | 1 | Counter reload request (circular) |
| irq_done | output | 1 | Gated complete interrupt |
| irq_half | output | 1 | Gated half interrupt |
| irq_err | output | 1 | Gated error interrupt |

## Verification
The bench builds the block with XADDR_W = 20 and SIZE_W = 3. REG_W stays at 32 and BUS_AW at 4. The odd widths let the peripheral and memory inputs carry values that differ in every field: a 3-bit size, opposite increments and unrelated 20-bit addresses. A swapped or partly swapped route therefore shows up on some output. Keeping a full 32-bit data word puts the upper bits in reach, so the bench can check that they read 0 after all-ones writes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int CTRL_W   = 6;
  localparam int B_EN     = 0;
  localparam int B_TCIE   = 1;
  localparam int B_HTIE   = 2;
  localparam int B_TEIE   = 3;
  localparam int B_DIR    = 4;
  localparam int B_CIRC   = 5;

  localparam int OFS_CTRL = 0;
  localparam int OFS_CLR  = 4;
  localparam int OFS_STAT = 8;

  localparam int NFLAG    = 3;
  localparam int FL_DONE  = 0;
  localparam int FL_HALF  = 1;
  localparam int FL_ERR   = 2;
  localparam int STAT_W   = NFLAG + 1;

  typedef struct packed {
    logic circ;
    logic dir;
    logic teie;
    logic htie;
    logic tcie;
    logic en;
  } ctrl_t;

  // next enable: error wins, then a bus write, then hold
  function automatic logic en_next_f(logic en, logic wr, logic wbit,
                                     logic err_flag, logic err_ev);
    if (err_ev)  return 1'b0;
    if (wr)      return en ? wbit : (wbit & ~err_flag);
    return en;
  endfunction

  // active marker: set on a fresh enable, cleared by a one-shot completion
  function automatic logic act_next_f(logic en_nx, logic rise, logic act,
                                      logic done_ev, logic circ);
    return en_nx & (rise | (act & ~(done_ev & ~circ)));
  endfunction

  function automatic logic irq_gate(logic flag, logic ie);
    return flag & ie;
  endfunction
endpackage

// File: rtl/dcc_ctrl_reg.sv
module dcc_ctrl_reg
  import dcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wbits,
  input  logic              err_flag,
  input  logic              ev_err,
  input  logic              ev_done,
  output ctrl_t             ctrl_q,
  output logic              active_q,
  output logic              en_rise
);
  logic en_nx;
  logic act_nx;
  logic cfg_wr;

  always_comb begin
    en_nx   = en_next_f(ctrl_q.en, wr_ctrl, wbits[B_EN], err_flag, ev_err);
    en_rise = ~ctrl_q.en & en_nx;
    act_nx  = act_next_f(en_nx, en_rise, active_q, ev_done, ctrl_q.circ);
    cfg_wr  = wr_ctrl & ~ctrl_q.en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      active_q <= 1'b0;
    end else begin
      ctrl_q.en <= en_nx;
      active_q  <= act_nx;
      if (cfg_wr) begin
        ctrl_q.tcie <= wbits[B_TCIE];
        ctrl_q.htie <= wbits[B_HTIE];
        ctrl_q.teie <= wbits[B_TEIE];
        ctrl_q.dir  <= wbits[B_DIR];
        ctrl_q.circ <= wbits[B_CIRC];
      end
    end
  end
endmodule

// File: rtl/dcc_flags.sv
module dcc_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_ev[i])  flag_q[i] <= 1'b1;
      else if (clr_req[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dcc_route.sv
module dcc_route #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic          dir,
  input  logic [SW-1:0] per_size,
  input  logic          per_inc,
  input  logic [AW-1:0] per_addr,
  input  logic [SW-1:0] mem_size,
  input  logic          mem_inc,
  input  logic [AW-1:0] mem_addr,
  output logic [SW-1:0] src_size,
  output logic          src_inc,
  output logic [AW-1:0] src_addr,
  output logic [SW-1:0] dst_size,
  output logic          dst_inc,
  output logic [AW-1:0] dst_addr
);
  localparam int BW = AW + SW + 1;
  logic [BW-1:0] per_b, mem_b, src_b, dst_b;

  always_comb begin
    per_b = {per_addr, per_size, per_inc};
    mem_b = {mem_addr, mem_size, mem_inc};
    src_b = dir ? mem_b : per_b;
    dst_b = dir ? per_b : mem_b;
    {src_addr, src_size, src_inc} = src_b;
    {dst_addr, dst_size, dst_inc} = dst_b;
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
#(
  parameter int BUS_AW  = 4,
  parameter int REG_W   = 32,
  parameter int XADDR_W = 32,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               ev_err,
  input  logic               ev_half,
  input  logic               ev_done,
  input  logic [SIZE_W-1:0]  per_size,
  input  logic               per_inc,
  input  logic [XADDR_W-1:0] per_addr,
  input  logic [SIZE_W-1:0]  mem_size,
  input  logic               mem_inc,
  input  logic [XADDR_W-1:0] mem_addr,
  output logic [SIZE_W-1:0]  src_size,
  output logic               src_inc,
  output logic [XADDR_W-1:0] src_addr,
  output logic [SIZE_W-1:0]  dst_size,
  output logic               dst_inc,
  output logic [XADDR_W-1:0] dst_addr,
  output logic               ch_en,
  output logic               ch_circ,
  output logic               ch_active,
  output logic               reload_pulse,
  output logic               irq_done,
  output logic               irq_half,
  output logic               irq_err
);
  // named internal events, also seen by the bound checker
  logic             sel_ctrl, sel_clr, sel_stat;
  logic             wr_ctrl, wr_clr;
  logic             en_q, circ_q, dir_q, tcie_q, err_q, active_q, en_rise;
  logic [4:0]       cfg_bits;
  logic [NFLAG-1:0] flag_q, flag_set, flag_clr;
  ctrl_t            ctrl_q;

  assign sel_ctrl = (reg_addr == BUS_AW'(OFS_CTRL));
  assign sel_clr  = (reg_addr == BUS_AW'(OFS_CLR));
  assign sel_stat = (reg_addr == BUS_AW'(OFS_STAT));
  assign wr_ctrl  = reg_wr & sel_ctrl;
  assign wr_clr   = reg_wr & sel_clr;

  dcc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wbits    (reg_wdata[CTRL_W-1:0]),
    .err_flag (err_q),
    .ev_err   (ev_err),
    .ev_done  (ev_done),
    .ctrl_q   (ctrl_q),
    .active_q (active_q),
    .en_rise  (en_rise)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FL_DONE] = ev_done;
    flag_set[FL_HALF] = ev_half;
    flag_set[FL_ERR]  = ev_err;
    flag_clr          = wr_clr ? reg_wdata[NFLAG-1:0] : '0;
  end

  dcc_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (flag_set),
    .clr_req (flag_clr),
    .flag_q  (flag_q)
  );

  dcc_route #(.AW(XADDR_W), .SW(SIZE_W)) u_route (
    .dir      (ctrl_q.dir),
    .per_size (per_size),
    .per_inc  (per_inc),
    .per_addr (per_addr),
    .mem_size (mem_size),
    .mem_inc  (mem_inc),
    .mem_addr (mem_addr),
    .src_size (src_size),
    .src_inc  (src_inc),
    .src_addr (src_addr),
    .dst_size (dst_size),
    .dst_inc  (dst_inc),
    .dst_addr (dst_addr)
  );

  assign en_q     = ctrl_q.en;
  assign circ_q   = ctrl_q.circ;
  assign dir_q    = ctrl_q.dir;
  assign tcie_q   = ctrl_q.tcie;
  assign err_q    = flag_q[FL_ERR];
  assign cfg_bits = {ctrl_q.circ, ctrl_q.dir, ctrl_q.teie, ctrl_q.htie, ctrl_q.tcie};

  assign ch_en        = ctrl_q.en;
  assign ch_circ      = ctrl_q.circ;
  assign ch_active    = active_q;
  assign reload_pulse = ev_done & ~ev_err & ctrl_q.en & ctrl_q.circ & active_q;
  assign irq_done     = irq_gate(flag_q[FL_DONE], ctrl_q.tcie);
  assign irq_half     = irq_gate(flag_q[FL_HALF], ctrl_q.htie);
  assign irq_err      = irq_gate(flag_q[FL_ERR],  ctrl_q.teie);

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)      reg_rdata[CTRL_W-1:0] = ctrl_q;
    else if (sel_stat) reg_rdata[STAT_W-1:0] = {active_q, flag_q};
  end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_err,
  input logic          ev_done,
  input logic          wr_ctrl,
  input logic          en_q,
  input logic          circ_q,
  input logic          dir_q,
  input logic          tcie_q,
  input logic          err_q,
  input logic          active_q,
  input logic [4:0]    cfg_bits,
  input logic          irq_done,
  input logic          reload_pulse,
  input logic [AW-1:0] per_addr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr
);
  AST_ERR_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (!en_q && err_q)); // R4
  AST_REARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !en_q) |=> !en_q); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(cfg_bits)); // R3
  AST_IRQ_DONE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && tcie_q && !wr_ctrl) |=> irq_done); // R8
  AST_ROUTE_MEM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q |-> (src_addr == mem_addr && dst_addr == per_addr)); // R7
  AST_IDLE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && en_q && !circ_q && !ev_err && !wr_ctrl) |=> (en_q && !active_q)); // R10
  AST_RELOAD_ONLY_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> (en_q && circ_q && active_q)); // R9
endmodule

bind dma_chan_ctrl dcc_checker #(.AW(XADDR_W)) i_dcc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_err       (ev_err),
  .ev_done      (ev_done),
  .wr_ctrl      (wr_ctrl),
  .en_q         (en_q),
  .circ_q       (circ_q),
  .dir_q        (dir_q),
  .tcie_q       (tcie_q),
  .err_q        (err_q),
  .active_q     (active_q),
  .cfg_bits     (cfg_bits),
  .irq_done     (irq_done),
  .reload_pulse (reload_pulse),
  .per_addr     (per_addr),
  .mem_addr     (mem_addr),
  .src_addr     (src_addr),
  .dst_addr     (dst_addr)
);

// File: tb/test_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl;
  localparam int BUS_AW = 4;
  localparam int REG_W  = 32;
  localparam int XA     = 20;
  localparam int SW     = 3;
  localparam logic [BUS_AW-1:0] A_CTRL = 4'h0;
  localparam logic [BUS_AW-1:0] A_CLR  = 4'h4;
  localparam logic [BUS_AW-1:0] A_STAT = 4'h8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [BUS_AW-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              ev_err = 1'b0, ev_half = 1'b0, ev_done = 1'b0;
  logic [SW-1:0]     per_size = '0, mem_size = '0;
  logic              per_inc = 1'b0, mem_inc = 1'b0;
  logic [XA-1:0]     per_addr = '0, mem_addr = '0;
  logic [SW-1:0]     src_size, dst_size;
  logic              src_inc, dst_inc;
  logic [XA-1:0]     src_addr, dst_addr;
  logic              ch_en, ch_circ, ch_active, reload_pulse;
  logic              irq_done, irq_half, irq_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic seen_reload;

  always #2 clk = ~clk; // 250 MHz

  dma_chan_ctrl #(.BUS_AW(BUS_AW), .REG_W(REG_W), .XADDR_W(XA), .SIZE_W(SW)) i_dma_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_err(ev_err), .ev_half(ev_half), .ev_done(ev_done),
    .per_size(per_size), .per_inc(per_inc), .per_addr(per_addr),
    .mem_size(mem_size), .mem_inc(mem_inc), .mem_addr(mem_addr),
    .src_size(src_size), .src_inc(src_inc), .src_addr(src_addr),
    .dst_size(dst_size), .dst_inc(dst_inc), .dst_addr(dst_addr),
    .ch_en(ch_en), .ch_circ(ch_circ), .ch_active(ch_active),
    .reload_pulse(reload_pulse),
    .irq_done(irq_done), .irq_half(irq_half), .irq_err(irq_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [BUS_AW-1:0] a, logic [REG_W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [BUS_AW-1:0] a, output logic [REG_W-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // kind: 0 done, 1 half, 2 error; records reload_pulse while the pulse is up
  task automatic pulse(int kind);
    @(negedge clk);
    if (kind == 0) ev_done = 1'b1;
    else if (kind == 1) ev_half = 1'b1;
    else ev_err = 1'b1;
    #0.5;
    seen_reload = reload_pulse;
    @(negedge clk);
    ev_done = 1'b0; ev_half = 1'b0; ev_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [REG_W-1:0] d;
    rd(A_CTRL, d); chk("R1 ctrl after reset", d, 0);
    rd(A_STAT, d); chk("R1 status after reset", d, 0);
    chk("R1 irq/reload after reset", {irq_done, irq_half, irq_err, reload_pulse}, 0);
  endtask

  task automatic t_layout();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, d); chk("R2 config bits stored, upper bits zero", d, 32'h3E);
    wr(A_CTRL, 32'h0000_0014);
    rd(A_CTRL, d); chk("R2 second pattern", d, 32'h14);
    wr(A_CTRL, 0);
  endtask

  task automatic t_lock();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'h03);
    rd(A_CTRL, d); chk("R3 enabled with complete-irq enable", d, 32'h03);
    wr(A_CTRL, 32'hFFFF_FFFD);
    rd(A_CTRL, d); chk("R3 config ignored while enabled", d, 32'h03);
    wr(A_CTRL, 32'h3C);
    rd(A_CTRL, d); chk("R3 write 0 drops enable, config kept", d, 32'h02);
    wr(A_CTRL, 0);
    wr(A_CLR, 32'h7);
  endtask

  task automatic t_error();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'h09);
    pulse(2);
    rd(A_CTRL, d); chk("R4 enable cleared by error", d, 32'h08);
    rd(A_STAT, d); chk("R4 error flag set", d[2], 1);
    chk("R8 error irq raised", irq_err, 1);
    wr(A_CTRL, 32'h09);
    rd(A_CTRL, d); chk("R5 re-enable ignored with flag set", d, 32'h08);
    wr(A_CLR, 32'h4);
    rd(A_STAT, d); chk("R5 error flag cleared", d, 0);
    chk("R8 error irq gone", irq_err, 0);
    wr(A_CTRL, 32'h09);
    rd(A_CTRL, d); chk("R5 re-enable after clear", d, 32'h09);
    wr(A_CTRL, 0);
    wr(A_CLR, 32'h7);
  endtask

  task automatic t_route();
    per_size = 3'd5; per_inc = 1'b1; per_addr = 20'hA5A5A;
    mem_size = 3'd2; mem_inc = 1'b0; mem_addr = 20'h1234F;
    wr(A_CTRL, 32'h00);
    #0.5;
    chk("R6 source from peripheral", {src_addr, src_size, src_inc}, {20'hA5A5A, 3'd5, 1'b1});
    chk("R6 destination from memory", {dst_addr, dst_size, dst_inc}, {20'h1234F, 3'd2, 1'b0});
    wr(A_CTRL, 32'h10);
    #0.5;
    chk("R7 source from memory", {src_addr, src_size, src_inc}, {20'h1234F, 3'd2, 1'b0});
    chk("R7 destination from peripheral", {dst_addr, dst_size, dst_inc}, {20'hA5A5A, 3'd5, 1'b1});
    wr(A_CTRL, 32'h11);
    per_addr = 20'h0F0F0;
    #0.5;
    chk("R7 follows live input while enabled", dst_addr, 20'h0F0F0);
    wr(A_CTRL, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_irq();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'h06);
    pulse(1);
    chk("R8 half irq", {irq_half, irq_done}, 2'b10);
    pulse(0);
    chk("R8 both irqs", {irq_half, irq_done}, 2'b11);
    wr(A_CTRL, 32'h00);
    chk("R8 irqs masked by enables", {irq_half, irq_done}, 0);
    rd(A_STAT, d); chk("R8 flags remain", d, 32'h3);
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R8 complete flag cleared alone", d, 32'h2);
    wr(A_CLR, 32'h2);
    rd(A_STAT, d); chk("R8 half flag cleared", d, 0);
  endtask

  task automatic t_circ();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'h21);
    rd(A_STAT, d); chk("R10 active set on enable", d, 32'h8);
    pulse(0);
    chk("R9 reload in circular mode", seen_reload, 1);
    rd(A_STAT, d); chk("R9 still active after reload", d, 32'h9);
    chk("R9 enable held", ch_en, 1);
    wr(A_CTRL, 0);
    wr(A_CLR, 32'h7);
  endtask

  task automatic t_oneshot();
    logic [REG_W-1:0] d;
    wr(A_CTRL, 32'h01);
    pulse(0);
    chk("R9 no reload outside circular mode", seen_reload, 0);
    rd(A_CTRL, d); chk("R10 enable kept after completion", d, 32'h01);
    rd(A_STAT, d); chk("R10 idle with complete flag", d, 32'h1);
    wr(A_CTRL, 0);
    wr(A_CTRL, 32'h01);
    rd(A_STAT, d); chk("R10 active again after re-enable", d[3], 1);
    wr(A_CTRL, 0);
    wr(A_CLR, 32'h7);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_lock();
    t_error();
    t_route();
    t_irq();
    t_circ();
    t_oneshot();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule